// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the protocol engine on the slave side of a two-wire serial memory that holds 4096 bytes. It receives SCL and SDA that have already been synchronised to the system clock. From them it finds START and STOP conditions and shifts bytes in and out, most significant bit first. The first byte after each START is a control byte. That byte is checked against a fixed four-bit device code and three strap pins. The engine then acknowledges, or stays silent, on the ninth clock.

A write control byte is followed by two address bytes that load a 12-bit pointer. Any further bytes are data. Each data byte goes out on a valid/ready port to a write cache, and the pointer then steps forward. A read control byte streams bytes from the pointer through a synchronous RAM read port. The engine keeps streaming while the master acknowledges and stops at the master's NACK. A random read is a write control byte and two address bytes, then a repeated START and a read control byte. While the `busy_i` input signals that a self-timed programming cycle is running, the engine acknowledges nothing. A master can therefore poll with a write control byte until it sees an ACK.

The write port follows valid/ready rules. `wr_valid_o` stays high, with `wr_addr_o` and `wr_data_o` held constant, until the cycle in which `wr_ready_i` is high. A data byte that completes while the previous one is still waiting is refused with a NACK and discarded, and the pointer does not move. The read port has no back-pressure: data is expected on `mem_rdata_i` one clock after `mem_rd_en_o`.

Top module: `ee_i2c_slave`

## Requirements
- R1: A control byte acknowledges only when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap_i`. Bit 0 selects read (1) or write (0). On a mismatch the engine NACKs and ignores all bytes until the next START.
- R2: While `busy_i` is high, the engine drives no ACK on any byte, including its own control byte. The ACK returns once `busy_i` is low.
- R3: After a write control byte, two address bytes follow, high byte first, and each is acknowledged. The low four bits of the high byte and the whole low byte form the 12-bit pointer. The upper four bits of the high byte are ignored.
- R4: Each data byte in a write is presented on the write port with `wr_addr_o` equal to the pointer. It is acknowledged, and the pointer then steps by one.
- R5: `wr_valid_o`, `wr_addr_o` and `wr_data_o` stay unchanged until `wr_ready_i` is high. A data byte that completes while the previous one is still pending is NACKed and dropped, and the pointer is left as it was.
- R6: After a random read (address bytes, repeated START, read control byte), the first returned byte comes from the loaded address.
- R7: A current-address read returns the byte one past the last byte accessed, whether that access was a read or a write.
- R8: When the master ACKs a read byte, the next sequential byte is sent. The pointer wraps from 0xFFF to 0x000.
- R9: When the master NACKs a read byte, the engine releases SDA. It drives nothing on later clocks until a START or STOP.
- R10: `sda_oe_o` changes only while SCL is low. The change happens `HOLD_CYC` clocks after the SCL falling edge.
- R11: A START or STOP in the middle of a byte abandons that byte. After a START, the next byte is decoded as a control byte, and the pointer is unchanged.
- R12: `wr_commit_o` pulses for one clock on the STOP that ends a transaction that delivered at least one data byte. It does not pulse otherwise.
- R13: After reset, SDA is released, `wr_valid_o` is low and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (wired line level) |
| strap_i | input | 3 | Chip-select strap pins compared with control bits 3:1 |
| busy_i | input | 1 | High while a self-timed programming cycle runs |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_rd_en_o | output | 1 | Read strobe to the memory array |
| mem_addr_o | output | 12 | Read address to the memory array |
| mem_rdata_i | input | 8 | Read data, valid one clock after the strobe |
| wr_valid_o | output | 1 | Write byte offered to the cache |
| wr_ready_i | input | 1 | Cache accepts the offered byte |
| wr_addr_o | output | 12 | Address of the offered byte |
| wr_data_o | output | 8 | Offered data byte |
| wr_commit_o | output | 1 | One-clock pulse: start the programming cycle |

## Verification
A bad decode state or bit count shows first on SDA. An ACK appears or goes missing on the ninth clock of the very byte concerned, or a read byte arrives shifted. A pointer that has drifted stays hidden until the next read. That read returns a byte from the wrong address, so every write and sequential read is followed by current-address reads. A write-port handshake fault shows within one byte time, as lost, doubled or altered data when the bytes are read back.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 3;
  localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADRH,
    ST_ADRL,
    ST_WDATA,
    ST_RDATA
  } ee_state_t;
endpackage

// File: rtl/ee_line_events.sv
module ee_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moving while SCL stays high is a bus condition, never data
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_sda_driver.sv
module ee_sda_driver #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic load_i,
  input  logic val_i,
  output logic sda_oe_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      upd_q    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (load_i) begin
      pend_q <= val_i;
      upd_q  <= 1'b1;
      cnt_q  <= CNT_W'(HOLD_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (upd_q && !scl_i) begin
      sda_oe_o <= pend_q;
      upd_q    <= 1'b0;
    end
  end

  // R10: the line driver never moves while SCL is high
  assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_i));
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_i2c_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] ACK_DONE = 4'd9;

  ee_state_t         state_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q, tx_q, rbuf_q;
  logic [HI_W-1:0]   adr_hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q, miss_q, mack_q, wrote_q, rd_q;
  logic              drv_load, drv_val;
  logic              ev_rise, ev_fall, ev_start, ev_stop;
  logic              ctrl_hit;

  ee_line_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (ev_rise),
    .scl_fall_o (ev_fall),
    .start_o    (ev_start),
    .stop_o     (ev_stop)
  );

  ee_sda_driver #(.HOLD_CYC(HOLD_CYC)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .load_i   (drv_load),
    .val_i    (drv_val),
    .sda_oe_o (sda_oe_o)
  );

  assign ctrl_hit = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      rbuf_q      <= '0;
      adr_hi_q    <= '0;
      ptr_q       <= '0;
      rw_q        <= 1'b0;
      miss_q      <= 1'b0;
      mack_q      <= 1'b0;
      wrote_q     <= 1'b0;
      rd_q        <= 1'b0;
      drv_load    <= 1'b0;
      drv_val     <= 1'b0;
      mem_rd_en_o <= 1'b0;
      mem_addr_o  <= '0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      mem_rd_en_o <= 1'b0;
      wr_commit_o <= 1'b0;
      drv_load    <= 1'b0;
      rd_q        <= mem_rd_en_o;
      if (rd_q) rbuf_q <= mem_rdata_i;
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;

      if (ev_start) begin
        state_q  <= ST_CTRL;
        bitcnt_q <= '0;
        miss_q   <= 1'b0;
        drv_load <= 1'b1;
        drv_val  <= 1'b0;
      end else if (ev_stop) begin
        state_q     <= ST_IDLE;
        bitcnt_q    <= '0;
        drv_load    <= 1'b1;
        drv_val     <= 1'b0;
        wr_commit_o <= wrote_q;
        wrote_q     <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (ev_rise) begin
          if (bitcnt_q < ACK_SLOT) shreg_q <= {shreg_q[6:0], sda_i};
          else                     mack_q  <= ~sda_i;
          if (bitcnt_q != ACK_DONE) bitcnt_q <= bitcnt_q + 4'd1;
        end else if (ev_fall) begin
          if (bitcnt_q == ACK_SLOT) begin
            // entering the ninth clock: decide whether to acknowledge
            drv_load <= 1'b1;
            drv_val  <= 1'b0;
            case (state_q)
              ST_CTRL: begin
                if (ctrl_hit && !busy_i) begin
                  drv_val <= 1'b1;
                  rw_q    <= shreg_q[0];
                  if (shreg_q[0]) begin
                    mem_rd_en_o <= 1'b1;
                    mem_addr_o  <= ptr_q;
                  end
                end else miss_q <= 1'b1;
              end
              ST_ADRH: begin
                if (!busy_i) begin
                  drv_val  <= 1'b1;
                  adr_hi_q <= shreg_q[HI_W-1:0];
                end else miss_q <= 1'b1;
              end
              ST_ADRL: begin
                if (!busy_i) begin
                  drv_val <= 1'b1;
                  ptr_q   <= {adr_hi_q, shreg_q};
                end else miss_q <= 1'b1;
              end
              ST_WDATA: begin
                if (!busy_i && !wr_valid_o) begin
                  drv_val    <= 1'b1;
                  wr_valid_o <= 1'b1;
                  wr_addr_o  <= ptr_q;
                  wr_data_o  <= shreg_q;
                  ptr_q      <= ptr_q + PTR_ONE;
                  wrote_q    <= 1'b1;
                end
              end
              ST_RDATA: begin
                mem_rd_en_o <= 1'b1;
                mem_addr_o  <= ptr_q;
              end
              default: ;
            endcase
          end else if (bitcnt_q == ACK_DONE) begin
            bitcnt_q <= '0;
            miss_q   <= 1'b0;
            drv_load <= 1'b1;
            drv_val  <= 1'b0;
            case (state_q)
              ST_CTRL: begin
                if (miss_q) state_q <= ST_IDLE;
                else if (rw_q) begin
                  state_q <= ST_RDATA;
                  tx_q    <= rbuf_q;
                  drv_val <= ~rbuf_q[7];
                  ptr_q   <= ptr_q + PTR_ONE;
                end else state_q <= ST_ADRH;
              end
              ST_ADRH:  state_q <= miss_q ? ST_IDLE : ST_ADRL;
              ST_ADRL:  state_q <= miss_q ? ST_IDLE : ST_WDATA;
              ST_RDATA: begin
                if (mack_q) begin
                  tx_q    <= rbuf_q;
                  drv_val <= ~rbuf_q[7];
                  ptr_q   <= ptr_q + PTR_ONE;
                end else state_q <= ST_IDLE;
              end
              default: ;
            endcase
          end else if (state_q == ST_RDATA && bitcnt_q != '0) begin
            drv_load <= 1'b1;
            drv_val  <= ~tx_q[6];
            tx_q     <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R5: an offered byte is held until the cache takes it
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o)));

  // R2: no byte is accepted while a programming cycle runs
  assert_wr_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> !$past(busy_i));

  // R11: a START always restarts control-byte decoding
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state_q == ST_CTRL && bitcnt_q == 4'd0));

  // R12: the commit pulse comes only from a STOP
  assert_commit_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(ev_stop));

  // R8: array reads are requested only while serving a read
  assert_rd_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> (state_q == ST_CTRL || state_q == ST_RDATA));
endmodule

// File: tb/tb_ee_i2c_slave.sv
module tb_ee_i2c_slave;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0, wr_rdy = 1'b1;
  logic sda_line;
  logic sda_oe, mem_rd_en, wr_valid, wr_commit;
  logic [11:0] mem_addr, wr_addr;
  logic [7:0] mem_rdata, wr_data;

  assign sda_line = sda_m & ~sda_oe;

  ee_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .busy_i(busy), .sda_oe_o(sda_oe),
    .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_rdy), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  int checks = 0, errors = 0, commits = 0, viol = 0;
  bit done = 1'b0;
  logic [7:0] mem [4096];
  logic [7:0] exp_mem [4096];
  logic [11:0] exp_ptr = 12'h000;
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (wr_valid && wr_rdy) mem[wr_addr] <= wr_data;
      if (wr_commit) commits++;
    end
  end

  // R10 monitor: drive changes must fall in SCL low time
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_prev) viol++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input int n, input logic [7:0] b);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(8, b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = ~sda_line;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0;
    end
    w(Q); sda_m = ~give_ack; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic write_one(input logic [11:0] a, input logic [7:0] d);
    logic k0, k1, k2, k3;
    bus_start();
    send_byte(ctl(1'b0), k0);
    send_byte({4'h0, a[11:8]}, k1);
    send_byte(a[7:0], k2);
    send_byte(d, k3);
    bus_stop();
    w(4);
    chk("R1 write control ack", k0, 1);
    chk("R3 address acks", {k1, k2}, 2'b11);
    chk("R4 data ack", k3, 1);
    exp_mem[a] = d;
    exp_ptr = a + 12'd1;
  endtask

  task automatic rand_read(input logic [11:0] a, input int n, input string req);
    logic k0, k1, k2, k3;
    logic [7:0] b;
    bus_start();
    send_byte(ctl(1'b0), k0);
    send_byte({4'h0, a[11:8]}, k1);
    send_byte(a[7:0], k2);
    bus_start();
    send_byte(ctl(1'b1), k3);
    chk("R6 random read acks", {k0, k1, k2, k3}, 4'hF);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, b, exp_mem[12'(a + 12'(i))]);
    end
    bus_stop();
    exp_ptr = 12'(a + 12'(n));
  endtask

  task automatic cur_read(input int n);
    logic k;
    logic [7:0] b;
    bus_start();
    send_byte(ctl(1'b1), k);
    chk("R7 current read ack", k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk("R7 current read data", b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 12'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic k, k1, k2;
    logic [7:0] b;
    int c0;
    void'($urandom(32'd20240));
    for (int i = 0; i < 4096; i++) exp_mem[i] = pat(i);
    w(5);
    rst_n = 1'b1;
    w(2);
    chk("R13 reset sda released", sda_oe, 0);
    chk("R13 reset no write", wr_valid, 0);
    chk("R13 reset no read", mem_rd_en, 0);

    // byte write, commit pulse, current reads after write and after read
    write_one(12'h123, 8'h5A);
    chk("R12 commit after data", commits, 1);
    cur_read(1);
    rand_read(12'h123, 1, "R6 random read data");
    cur_read(1);

    // sequential read crossing the top of the array
    rand_read(12'hFFE, 4, "R8 sequential wrap data");
    cur_read(1);

    // upper nibble of the high address byte is ignored
    bus_start();
    send_byte(ctl(1'b0), k); send_byte(8'hF1, k1); send_byte(8'h23, k2);
    chk("R3 nibble ignored acks", {k, k1, k2}, 3'b111);
    bus_start(); send_byte(ctl(1'b1), k);
    recv_byte(1'b0, b);
    chk("R3 masked address data", b, 8'h5A);
    bus_stop();
    exp_ptr = 12'h124;

    // control mismatches
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, k);
    chk("R1 strap mismatch nack", k, 0);
    send_byte(8'h00, k);
    chk("R1 ignored after mismatch", k, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, k);
    chk("R1 code mismatch nack", k, 0);
    bus_stop();
    cur_read(1);

    // acknowledge polling while busy
    busy = 1'b1;
    bus_start(); send_byte(ctl(1'b0), k); bus_stop();
    chk("R2 busy write poll nack", k, 0);
    bus_start(); send_byte(ctl(1'b1), k); bus_stop();
    chk("R2 busy read nack", k, 0);
    busy = 1'b0;
    bus_start(); send_byte(ctl(1'b0), k); bus_stop();
    chk("R2 ack after busy", k, 1);
    cur_read(1);

    // master NACK then extra clocks: engine stays off the line
    bus_start();
    send_byte(ctl(1'b0), k); send_byte(8'h02, k); send_byte(8'h40, k);
    bus_start(); send_byte(ctl(1'b1), k);
    recv_byte(1'b0, b);
    chk("R9 data before nack", b, exp_mem[12'h240]);
    recv_byte(1'b0, b);
    chk("R9 released after nack", b, 8'hFF);
    chk("R9 no drive after nack", sda_oe, 0);
    bus_stop();
    exp_ptr = 12'h241;

    // START in mid-byte, then STOP in mid-byte
    bus_start(); send_byte(ctl(1'b0), k);
    send_bits(4, 8'hF0);
    bus_start(); send_byte(ctl(1'b1), k);
    chk("R11 control after abort ack", k, 1);
    recv_byte(1'b0, b);
    chk("R11 pointer kept after abort", b, exp_mem[exp_ptr]);
    bus_stop();
    exp_ptr = exp_ptr + 12'd1;
    bus_start(); send_byte(ctl(1'b0), k);
    send_bits(3, 8'h00);
    bus_stop();
    cur_read(1);

    // write back-pressure
    c0 = commits;
    wr_rdy = 1'b0;
    bus_start();
    send_byte(ctl(1'b0), k); send_byte(8'h03, k); send_byte(8'h30, k);
    send_byte(8'hC3, k1); send_byte(8'h3C, k2);
    chk("R5 first byte ack", k1, 1);
    chk("R5 pending byte nack", k2, 0);
    chk("R5 valid held", {wr_valid, wr_addr, wr_data}, {1'b1, 12'h330, 8'hC3});
    bus_stop();
    w(4);
    wr_rdy = 1'b1;
    w(4);
    chk("R5 valid dropped after ready", wr_valid, 0);
    chk("R12 commit after pressured write", commits, c0 + 1);
    exp_mem[12'h330] = 8'hC3;
    exp_ptr = 12'h331;
    cur_read(1);
    rand_read(12'h330, 2, "R5 readback");

    // address-only transaction must not commit
    c0 = commits;
    bus_start();
    send_byte(ctl(1'b0), k); send_byte(8'h07, k); send_byte(8'h77, k);
    bus_stop();
    w(4);
    chk("R12 no commit without data", commits, c0);
    exp_ptr = 12'h777;
    cur_read(2);

    // constrained random traffic
    for (int it = 0; it < 24; it++) begin
      int op;
      logic [11:0] a;
      op = int'($urandom % 3);
      a = 12'($urandom);
      if (op == 0) write_one(a, 8'($urandom));
      else if (op == 1) rand_read(a, 1 + int'($urandom % 5), "R8 random sequential data");
      else cur_read(1 + int'($urandom % 4));
    end

    chk("R10 drive changes only in SCL low", viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule